// File: doc/BRIEF.md
# DAC Sample Source Selector with Synchronized Start

This block builds the two-channel sample stream that a converter's serial interface consumes. Each time the serial side asks for a new sample by pulsing `sample_req`, the block takes one sample pair from the source chosen on `src_sel`. The source is one of three: a DMA stream carrying both channels in one word, two independent channel inputs each with its own valid, or an internal counting ramp used for bring-up. The block drives `dma_ready` back to the DMA, and a DMA word is consumed only in a cycle where ready and valid are both high.

When several converter controllers must start together, `sync_arm` holds back the DMA stream. Streaming starts only once the primary DMA valid is high together with either a secondary DMA valid or an external sync flag from a peer. The block then holds the start until the sync is disarmed, and it announces its own start to peers with a one-clock pulse on `sync_out`. The synchronized start applies only while the DMA is the selected source.

Top module: `dac_src_sel`

## Requirements
- R1: After reset, `out_valid`, `out_a`, `out_b`, `dma_ready` and `sync_out` are all 0, and the ramp count is 0.
- R2: Source code 0 selects the DMA. In a cycle with `sample_req` high, source 0 and the start open, `dma_ready` is high. If `dma_valid` is also high, one clock later `out_valid` is 1, `out_a` holds the DMA word's low DW bits and `out_b` holds its high DW bits.
- R3: Source code 1 selects the channel inputs. On a `sample_req` with both `ext_a_valid` and `ext_b_valid` high, one clock later `out_valid` is 1 with `out_a`=`ext_a` and `out_b`=`ext_b`. If either valid is low, no sample is taken.
- R4: Source code 2 selects the ramp. Each `sample_req` yields `out_a` equal to the ramp count and `out_b` equal to the count plus 1, both modulo 2^DW. The count then advances by 1 and wraps to 0 after 2^DW-1.
- R5: When no sample is taken (source code 3, or the selected source not valid), `out_valid` is 0 the next clock and `out_a`/`out_b` keep their previous values.
- R6: The source is sampled only on `sample_req` cycles. With `sample_req` low, `dma_ready` is 0, the next `out_valid` is 0 and the outputs do not change, whatever `src_sel` does.
- R7: With `sync_arm` high and source 0, `dma_ready` stays 0 until `dma_valid` and (`sec_valid` or `ext_sync`) are high in the same cycle. From then on, the start stays open until `sync_arm` goes low.
- R8: `sync_out` is high for exactly one clock, the cycle after the armed start condition is first met. It pulses again only after a disarm and a new start.
- R9: With a source other than 0, `sync_arm` has no effect: samples flow as in R3/R4 and `sync_out` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_req | input | 1 | One-clock request for the next sample pair |
| src_sel | input | 2 | 0 DMA, 1 channel inputs, 2 ramp, 3 idle |
| sync_arm | input | 1 | Enables the synchronized start for the DMA source |
| dma_data | input | 2*DW | DMA word, channel A low half, channel B high half |
| dma_valid | input | 1 | Primary DMA valid |
| dma_ready | output | 1 | Ready returned to the DMA |
| sec_valid | input | 1 | Secondary DMA valid |
| ext_sync | input | 1 | Start flag from a peer instance |
| sync_out | output | 1 | One-clock start notice to peers |
| ext_a | input | DW | Channel A input data |
| ext_a_valid | input | 1 | Channel A input valid |
| ext_b | input | DW | Channel B input data |
| ext_b_valid | input | 1 | Channel B input valid |
| out_a | output | DW | Channel A sample |
| out_b | output | DW | Channel B sample |
| out_valid | output | 1 | Sample pair is new this cycle |

## Verification
The bench builds the block with DW=8 rather than the default 16. This brings the ramp's wraparound, and channel B's wrap one count ahead of channel A, within a few hundred samples. A behavioural model tracks the ramp count and the sync level, and all outputs are compared against it every clock. The stimulus covers DMA words with the two halves distinct, mixed channel valids, source changes between requests, and arm/disarm sequences that open the start through the secondary valid and then through the peer flag.

// File: rtl/dac_src_sel.sv
module dac_src_sel #(
  parameter int DW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sample_req,
  input  logic [1:0]      src_sel,
  input  logic            sync_arm,
  input  logic [2*DW-1:0] dma_data,
  input  logic            dma_valid,
  output logic            dma_ready,
  input  logic            sec_valid,
  input  logic            ext_sync,
  output logic            sync_out,
  input  logic [DW-1:0]   ext_a,
  input  logic            ext_a_valid,
  input  logic [DW-1:0]   ext_b,
  input  logic            ext_b_valid,
  output logic [DW-1:0]   out_a,
  output logic [DW-1:0]   out_b,
  output logic            out_valid
);

  localparam logic [1:0] SRC_DMA  = 2'd0;
  localparam logic [1:0] SRC_EXT  = 2'd1;
  localparam logic [1:0] SRC_RAMP = 2'd2;

  logic [DW-1:0] ramp_q;
  logic          start_q;

  wire is_dma   = (src_sel == SRC_DMA);
  wire peer_ok  = dma_valid & (sec_valid | ext_sync);
  wire start_ev = sync_arm & is_dma & ~start_q & peer_ok;
  wire gate_ok  = ~sync_arm | start_q | peer_ok;

  assign dma_ready = sample_req & is_dma & gate_ok;

  wire take_dma  = dma_ready & dma_valid;
  wire take_ext  = sample_req & (src_sel == SRC_EXT) & ext_a_valid & ext_b_valid;
  wire take_ramp = sample_req & (src_sel == SRC_RAMP);
  wire take_any  = take_dma | take_ext | take_ramp;

  logic [DW-1:0] nxt_a, nxt_b;
  always_comb begin
    nxt_a = ramp_q;
    nxt_b = ramp_q + DW'(1);
    if (take_dma) begin
      nxt_a = dma_data[DW-1:0];
      nxt_b = dma_data[2*DW-1:DW];
    end else if (take_ext) begin
      nxt_a = ext_a;
      nxt_b = ext_b;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_a     <= '0;
      out_b     <= '0;
      out_valid <= 1'b0;
      ramp_q    <= '0;
      start_q   <= 1'b0;
      sync_out  <= 1'b0;
    end else begin
      out_valid <= take_any;
      if (take_any) begin
        out_a <= nxt_a;
        out_b <= nxt_b;
      end
      if (take_ramp) ramp_q <= ramp_q + DW'(1);
      sync_out <= start_ev;
      if (!sync_arm)     start_q <= 1'b0;
      else if (start_ev) start_q <= 1'b1;
    end
  end

  p_ready_on_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_req |-> !dma_ready);

  p_ready_dma_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dma_ready |-> (src_sel == SRC_DMA));

  p_no_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_req |=> (!out_valid && $stable(out_a) && $stable(out_b)));

  p_gate_closed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_arm && !start_q && !(dma_valid && (sec_valid || ext_sync))) |-> !dma_ready);

  p_sync_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_out |=> !sync_out);

  p_sync_dma_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_DMA) |=> !sync_out);

  p_ramp_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_ramp && $past(take_ramp) && out_valid) |=> (out_a == $past(out_a) + DW'(1)));

endmodule

// File: tb/dac_src_sel_tb.sv
module dac_src_sel_tb;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0;
  logic sample_req = 0, sync_arm = 0, dma_valid = 0, sec_valid = 0, ext_sync = 0;
  logic ext_a_valid = 0, ext_b_valid = 0;
  logic [1:0] src_sel = 2'd3;
  logic [2*DW-1:0] dma_data = '0;
  logic [DW-1:0] ext_a = '0, ext_b = '0;
  logic dma_ready, sync_out, out_valid;
  logic [DW-1:0] out_a, out_b;

  int checks = 0, errors = 0;
  string tag = "R1";
  bit done = 0;

  bit m_va, m_sync, m_lvl;
  int m_a, m_b, m_ramp;
  int syncs = 0;

  always #2 clk = ~clk;

  dac_src_sel #(.DW(DW)) u_dut (.*);

  function automatic bit exp_ready();
    return sample_req && src_sel == 2'd0 &&
           (!sync_arm || m_lvl || (dma_valid && (sec_valid || ext_sync)));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_va = 0; m_sync = 0; m_lvl = 0; m_a = 0; m_b = 0; m_ramp = 0;
    end else begin
      bit ev, rdy;
      rdy = exp_ready();
      ev = sync_arm && src_sel == 2'd0 && !m_lvl && dma_valid && (sec_valid || ext_sync);
      m_va = 0;
      if (sample_req) begin
        case (src_sel)
          2'd0: if (rdy && dma_valid) begin
                  m_va = 1; m_a = dma_data[DW-1:0]; m_b = dma_data[2*DW-1:DW];
                end
          2'd1: if (ext_a_valid && ext_b_valid) begin
                  m_va = 1; m_a = ext_a; m_b = ext_b;
                end
          2'd2: begin
                  m_va = 1; m_a = m_ramp; m_b = (m_ramp + 1) % (1 << DW);
                  m_ramp = (m_ramp + 1) % (1 << DW);
                end
          default: ;
        endcase
      end
      m_sync = ev;
      if (ev) syncs++;
      m_lvl = sync_arm ? (m_lvl || ev) : 0;
    end
  end

  task automatic chk(string nm, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, nm, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("out_valid", out_valid, m_va);
    chk("out_a", out_a, m_a);
    chk("out_b", out_b, m_b);
    chk("dma_ready", dma_ready, exp_ready());
    chk("sync_out", sync_out, m_sync);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1;
    #1;
    tag = "R1";
    chk("reset out_valid", out_valid, 0);
    chk("reset out_a", out_a, 0);
    chk("reset out_b", out_b, 0);
    chk("reset dma_ready", dma_ready, 0);
    chk("reset sync_out", sync_out, 0);
    step();

    tag = "R2";
    src_sel = 2'd0;
    for (int i = 0; i < 60; i++) begin
      sample_req = (i % 3) != 1;
      dma_valid  = (i % 5) != 2;
      dma_data   = 16'(i * 517 + 3);
      step();
    end

    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      sample_req = (i % 4) == 0;
      src_sel    = 2'(i % 4);
      dma_valid  = 1; ext_a_valid = 1; ext_b_valid = 1;
      dma_data   = 16'(i * 91);
      ext_a = 8'(i); ext_b = 8'(200 - i);
      step();
    end

    tag = "R3";
    src_sel = 2'd1;
    for (int i = 0; i < 40; i++) begin
      sample_req  = 1;
      ext_a_valid = (i % 3) != 0;
      ext_b_valid = (i % 4) != 1;
      ext_a = 8'(i * 7); ext_b = 8'(i * 13 + 1);
      step();
    end

    tag = "R5";
    src_sel = 2'd3;
    repeat (10) step();
    src_sel = 2'd0; dma_valid = 0;
    repeat (5) step();

    tag = "R4";
    src_sel = 2'd2;
    for (int i = 0; i < 600; i++) begin
      sample_req = (i % 7) != 3;
      step();
    end

    tag = "R7";
    src_sel = 2'd0; sample_req = 1; sync_arm = 1;
    dma_valid = 1; sec_valid = 0; ext_sync = 0; dma_data = 16'h1234;
    repeat (6) step();
    sec_valid = 1; step();
    sec_valid = 0;
    for (int i = 0; i < 10; i++) begin dma_data = 16'(i + 40); step(); end
    dma_valid = 0; repeat (3) step();
    dma_valid = 1; step();

    tag = "R8";
    sync_arm = 0; step();
    sync_arm = 1; repeat (4) step();
    ext_sync = 1; step();
    ext_sync = 0; repeat (6) step();
    chk("sync pulses", syncs, 2);

    tag = "R9";
    sync_arm = 0; step();
    sync_arm = 1; sec_valid = 1; ext_sync = 1;
    src_sel = 2'd2; repeat (10) step();
    src_sel = 2'd1; ext_a_valid = 1; ext_b_valid = 1; repeat (10) step();
    chk("no sync off-dma", syncs, 2);

    step();
    finish_run();
  end
endmodule